// File: doc/BRIEF.md
# Buffered SPI Command Engine

This block is a register-driven SPI master that runs whole transactions from a shared byte buffer. Software first places a two-byte operation header at the start of the buffer and then the bytes to send. A single write to the command register starts the transfer and selects a timing profile and a target chip-select line. The engine then shifts the requested number of bytes MSB first on a single data line. Received bytes go back into the same buffer from offset 0. A busy flag in the status register shows when the transfer has finished.

A control register sets one polarity bit per chip-select line, a serial clock gate enable and the idle clock level. The polarity bits apply at all times, so software can change the idle level of any line as well as its active level. For each profile a register holds the byte sent while a read-only operation runs. Transfers run in SPI mode 0 relative to the programmed clock polarity. Each bit takes two core clock cycles: in the first the data line is driven and the clock sits at its idle level, and in the second the clock is at its active level and the input is sampled on the closing edge.

Top module: `spieng`

## Requirements
- R1: After reset the engine is idle. The status register reads 0 and the control register reads 0x000000FF (all polarity bits set, gate off, idle clock low). Every chip-select output is high, the serial clock is low and the data output is low.
- R2: A start reads the header as a big-endian word: buffer byte 0 is bits [15:8] and byte 1 is bits [7:0]. Bits [9:0] give the byte count (up to 1023). Bits [14:13] give the opcode: 1 = read-write, 2 = write-only, 3 = read-only. Bit 11, the dual-line flag, has no effect on this single-line data path.
- R3: A write-only operation sends buffer bytes from offset 2 onward, MSB first, with exactly 8 active clock edges per byte. It leaves the whole buffer unchanged.
- R4: A read-only operation sends, for every byte, the fill byte of the selected profile. That byte lives in bits [7:0] of the register at address 0x100 + 4*profile. Received bytes are stored at buffer offsets 0, 1, 2 and so on.
- R5: A read-write operation sends bytes from buffer offset 2 onward and stores each received byte at offset 0 onward, in the same transfer.
- R6: A command write (address 0x004) with bit 0 set starts a transfer. Bits [10:8] select the profile and bits [14:12] select the chip-select line. Status bit 1 (address 0x008) reads 1 from the cycle after the start for exactly 18 cycles per byte, then reads 0.
- R7: A start request while busy is ignored. The running transfer keeps its chip-select line and its length, and the ignored command never drives its own line.
- R8: A byte count of 0 produces no serial clock edges and does not drive any chip-select line. The status register reads 0 in the cycle after the command.
- R9: Chip-select output i equals (transfer active on line i) XOR control bit i, where bits [7:0] of the control register (address 0x000) are the polarity bits. At most one line differs from its polarity bit, and a polarity change takes effect while idle.
- R10: Control bit 17 sets the idle serial clock level. When control bit 16 (clock gate) is 0, the serial clock stays at its idle level even during a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register or buffer write strobe |
| reg_addr | input | 12 | Byte address: 0x000 control, 0x004 command, 0x008 status, 0x100+4p profile fill, 0x200-0x3FF buffer |
| reg_wdata | input | 32 | Write data; buffer writes use bits [7:0] |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_o | output | 8 | Chip-select lines after polarity |

## Verification
Several behaviours are checked by the assertions on every cycle. While idle, the chip-select lines equal their polarity bits, the data line is low and the clock sits at its idle level. No more than one line is ever driven away from its polarity bit. With the gate off and the clock polarity unchanged, the serial clock stays still. A start arriving during a transfer leaves busy high and keeps the selected line. Only the bench scenarios, using a slave model that captures MOSI and returns a known pattern, can show the rest: the header decode, the byte order in the buffer, the fill byte, the per-byte timing and the zero-length case.

// File: rtl/spieng_pkg.sv
package spieng_pkg;
    typedef enum logic [1:0] {S_IDLE, S_LOAD, S_SHIFT, S_STORE} seq_st_e;

    localparam logic [1:0] OP_RW = 2'd1;
    localparam logic [1:0] OP_WR = 2'd2;
    localparam logic [1:0] OP_RD = 2'd3;

    localparam int CNT_W = 10;

    localparam logic [11:0] A_CTRL = 12'h000;
    localparam logic [11:0] A_CMD  = 12'h004;
    localparam logic [11:0] A_STAT = 12'h008;
    localparam int          PROF_BASE = 'h100;
    localparam int          BUF_BASE  = 'h200;
endpackage

// File: rtl/spieng_buf.sv
module spieng_buf #(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [7:0]    bus_wdata,
    output logic [7:0]    bus_rdata,
    input  logic          eng_we,
    input  logic [AW-1:0] eng_waddr,
    input  logic [7:0]    eng_wdata,
    input  logic [AW-1:0] eng_raddr,
    output logic [7:0]    eng_rdata,
    output logic [15:0]   hdr
);
    localparam int BYTES = 1 << AW;

    logic [7:0] mem [BYTES];

    // engine stores take priority over bus writes in the same cycle
    always_ff @(posedge clk) begin
        if (eng_we)      mem[eng_waddr] <= eng_wdata;
        else if (bus_we) mem[bus_addr]  <= bus_wdata;
    end

    assign bus_rdata = mem[bus_addr];
    assign eng_rdata = mem[eng_raddr];
    assign hdr       = {mem[0], mem[1]};
endmodule

// File: rtl/spieng_seq.sv
module spieng_seq
    import spieng_pkg::*;
#(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [15:0]   hdr_i,
    input  logic [2:0]    prof_i,
    input  logic [2:0]    csel_i,
    input  logic [7:0]    fill_i,
    input  logic [7:0]    rdata_i,
    input  logic          miso_i,
    output logic          busy_o,
    output logic [2:0]    prof_o,
    output logic [2:0]    csel_o,
    output logic [AW-1:0] raddr_o,
    output logic          we_o,
    output logic [AW-1:0] waddr_o,
    output logic [7:0]    wdata_o,
    output logic          act_o,
    output logic          mosi_o
);
    typedef struct packed {
        seq_st_e          st;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] idx;
        logic [1:0]       op;
        logic [2:0]       prof;
        logic [2:0]       csel;
        logic [2:0]       bitn;
        logic             ph;
        logic [7:0]       sh;
        logic [7:0]       rx;
    } seq_t;

    seq_t s_d, s_q;

    logic unused_hdr;
    assign unused_hdr = ^{hdr_i[15], hdr_i[12:10]};

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            S_IDLE: begin
                if (start_i) begin
                    s_d.op   = hdr_i[14:13];
                    s_d.cnt  = hdr_i[CNT_W-1:0];
                    s_d.prof = prof_i;
                    s_d.csel = csel_i;
                    s_d.idx  = '0;
                    if (hdr_i[CNT_W-1:0] != '0) s_d.st = S_LOAD;
                end
            end
            S_LOAD: begin
                s_d.sh   = (s_q.op == OP_RD) ? fill_i : rdata_i;
                s_d.bitn = '0;
                s_d.ph   = 1'b0;
                s_d.st   = S_SHIFT;
            end
            S_SHIFT: begin
                if (!s_q.ph) begin
                    s_d.ph = 1'b1;
                end else begin
                    s_d.ph = 1'b0;
                    s_d.rx = {s_q.rx[6:0], miso_i};
                    s_d.sh = {s_q.sh[6:0], 1'b0};
                    if (s_q.bitn == 3'd7) s_d.st = S_STORE;
                    else                  s_d.bitn = s_q.bitn + 3'd1;
                end
            end
            S_STORE: begin
                s_d.idx = s_q.idx + 1'b1;
                s_d.st  = (s_q.idx + 1'b1 == s_q.cnt) ? S_IDLE : S_LOAD;
            end
            default: s_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: S_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign busy_o  = (s_q.st != S_IDLE);
    assign prof_o  = s_q.prof;
    assign csel_o  = s_q.csel;
    assign raddr_o = AW'(s_q.idx + CNT_W'(2));
    assign we_o    = (s_q.st == S_STORE) && (s_q.op != OP_WR);
    assign waddr_o = AW'(s_q.idx);
    assign wdata_o = s_q.rx;
    assign act_o   = (s_q.st == S_SHIFT) && s_q.ph;
    assign mosi_o  = (s_q.st == S_SHIFT) && s_q.sh[7];
endmodule

// File: rtl/spieng.sv
module spieng
    import spieng_pkg::*;
#(
    parameter int             NCS     = 8,
    parameter int             NPROF   = 8,
    parameter int             BUF_AW  = 9,
    parameter logic [NCS-1:0] RST_POL = '1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_we,
    input  logic [11:0]    reg_addr,
    input  logic [31:0]    reg_wdata,
    output logic [31:0]    reg_rdata,
    output logic           sclk_o,
    output logic           mosi_o,
    input  logic           miso_i,
    output logic [NCS-1:0] cs_o
);
    localparam int PW        = $clog2(NPROF);
    localparam int BUF_BYTES = 1 << BUF_AW;

    typedef struct packed {
        logic [NCS-1:0]        pol;
        logic                  gate;
        logic                  cpol;
        logic [NPROF-1:0][7:0] fill;
    } regs_t;

    regs_t r_d, r_q;

    logic          start, busy, act, eng_we;
    logic          prof_hit, buf_hit;
    logic [2:0]    prof_q, csel;
    logic [PW-1:0] pidx;
    logic [7:0]    bus_rdata, eng_rdata, eng_wdata, pol8;
    logic [15:0]   hdr;
    logic [BUF_AW-1:0] eng_raddr, eng_waddr;
    logic          unused_wd;

    assign unused_wd = ^{reg_wdata[31:18], reg_wdata[15], reg_wdata[11]};

    assign prof_hit = (reg_addr[11:8] == 4'(PROF_BASE >> 8)) && (reg_addr[1:0] == 2'b00)
                      && (int'(reg_addr[7:2]) < NPROF);
    assign buf_hit  = (int'(reg_addr) >= BUF_BASE) && (int'(reg_addr) < BUF_BASE + BUF_BYTES);
    assign pidx     = reg_addr[2 +: PW];
    assign start    = reg_we && (reg_addr == A_CMD) && reg_wdata[0];

    always_comb begin
        r_d = r_q;
        if (reg_we && reg_addr == A_CTRL) begin
            r_d.pol  = reg_wdata[NCS-1:0];
            r_d.gate = reg_wdata[16];
            r_d.cpol = reg_wdata[17];
        end
        if (reg_we && prof_hit) r_d.fill[pidx] = reg_wdata[7:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{pol: RST_POL, gate: 1'b0, cpol: 1'b0, fill: '0};
        else        r_q <= r_d;
    end

    always_comb begin
        pol8 = '0;
        pol8[NCS-1:0] = r_q.pol;
        reg_rdata = '0;
        if (reg_addr == A_CTRL)      reg_rdata = {14'd0, r_q.cpol, r_q.gate, 8'd0, pol8};
        else if (reg_addr == A_STAT) reg_rdata = {30'd0, busy, 1'b0};
        else if (prof_hit)           reg_rdata = {24'd0, r_q.fill[pidx]};
        else if (buf_hit)            reg_rdata = {24'd0, bus_rdata};
    end

    spieng_buf #(.AW(BUF_AW)) u_buf (
        .clk       (clk),
        .bus_we    (reg_we && buf_hit),
        .bus_addr  (reg_addr[BUF_AW-1:0]),
        .bus_wdata (reg_wdata[7:0]),
        .bus_rdata (bus_rdata),
        .eng_we    (eng_we),
        .eng_waddr (eng_waddr),
        .eng_wdata (eng_wdata),
        .eng_raddr (eng_raddr),
        .eng_rdata (eng_rdata),
        .hdr       (hdr)
    );

    spieng_seq #(.AW(BUF_AW)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .hdr_i   (hdr),
        .prof_i  (reg_wdata[10:8]),
        .csel_i  (reg_wdata[14:12]),
        .fill_i  (r_q.fill[prof_q[PW-1:0]]),
        .rdata_i (eng_rdata),
        .miso_i  (miso_i),
        .busy_o  (busy),
        .prof_o  (prof_q),
        .csel_o  (csel),
        .raddr_o (eng_raddr),
        .we_o    (eng_we),
        .waddr_o (eng_waddr),
        .wdata_o (eng_wdata),
        .act_o   (act),
        .mosi_o  (mosi_o)
    );

    assign sclk_o = r_q.cpol ^ (r_q.gate & act);

    for (genvar i = 0; i < NCS; i++) begin : g_cs
        assign cs_o[i] = (busy && csel == 3'(i)) ^ r_q.pol[i];
    end
endmodule

// File: rtl/spieng_chk.sv
module spieng_chk #(
    parameter int NCS = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           busy,
    input logic           start,
    input logic [2:0]     csel,
    input logic [NCS-1:0] cs_o,
    input logic [NCS-1:0] pol,
    input logic           sclk,
    input logic           cpol,
    input logic           gate,
    input logic           mosi
);
    AST_IDLE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> cs_o == pol); // R9
    AST_ONE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cs_o ^ pol) <= 1); // R9
    AST_IDLE_MOSI: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mosi); // R1
    AST_IDLE_SCLK: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sclk == cpol); // R10
    AST_GATE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate && $stable(cpol)) |-> $stable(sclk)); // R10
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy && $stable(csel))); // R7
endmodule

bind spieng spieng_chk #(.NCS(NCS)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .busy  (busy),
    .start (start),
    .csel  (csel),
    .cs_o  (cs_o),
    .pol   (r_q.pol),
    .sclk  (sclk_o),
    .cpol  (r_q.cpol),
    .gate  (r_q.gate),
    .mosi  (mosi_o)
);

// File: tb/sim_spieng.sv
module sim_spieng;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sclk, mosi, miso;
    logic [7:0]  cs;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    spieng u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk_o(sclk),
        .mosi_o(mosi), .miso_i(miso), .cs_o(cs)
    );

    // slave model: captures MOSI on active edge, shifts pattern on trailing edge
    logic       cpol_tb = 1'b0;
    logic       slv_clr = 1'b0;
    logic       act;
    logic [7:0] cap [0:511];
    logic [7:0] in_sh;
    logic [7:0] cur;
    int         in_bits, out_bits;

    assign act = sclk ^ cpol_tb;

    function automatic logic [7:0] pat(int k);
        return 8'h3C ^ 8'(k * 29);
    endfunction

    always @(posedge act or posedge slv_clr) begin
        if (slv_clr) in_bits <= 0;
        else begin
            in_sh <= {in_sh[6:0], mosi};
            if (in_bits % 8 == 7) cap[in_bits / 8] <= {in_sh[6:0], mosi};
            in_bits <= in_bits + 1;
        end
    end

    always @(negedge act or posedge slv_clr) begin
        if (slv_clr) out_bits <= 0;
        else         out_bits <= out_bits + 1;
    end

    always_comb begin
        cur  = pat(out_bits / 8);
        miso = cur[3'(7 - (out_bits % 8))];
    end

    task automatic chk(input string req, input logic [31:0] act_v, input logic [31:0] exp_v);
        total++;
        if (act_v !== exp_v) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act_v, exp_v);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
    endtask

    task automatic slave_clear();
        slv_clr = 1'b1;
        #1 slv_clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic put_hdr(input logic [15:0] h);
        wr(12'h200, {24'd0, h[15:8]});
        wr(12'h201, {24'd0, h[7:0]});
    endtask

    // start a command and poll status until idle; returns busy cycles and CS seen
    task automatic run(input int csl, input int prof, output int cyc,
                       output logic [7:0] cs_seen, output logic sclk_moved);
        logic [31:0] s;
        logic        sc0;
        wr(12'h004, 32'h1 | (prof << 8) | (csl << 12));
        cyc = 0;
        cs_seen = cs;
        sc0 = sclk;
        sclk_moved = 1'b0;
        do begin
            if (cyc == 1) cs_seen = cs;
            if (sclk !== sc0) sclk_moved = 1'b1;
            rd(12'h008, s);
            if (s[1]) cyc++;
        end while (s[1] && cyc < 20000);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(12'h008, d); chk("R1 status", d, 32'h0);
        rd(12'h000, d); chk("R1 ctrl", d, 32'h0000_00FF);
        chk("R1 cs", {24'd0, cs}, 32'hFF);
        chk("R1 sclk/mosi", {30'd0, sclk, mosi}, 32'h0);
    endtask

    task automatic t_write_only();
        int cyc; logic [7:0] cs_seen; logic mv; logic [31:0] d;
        put_hdr(16'h4003);
        wr(12'h202, 32'h11); wr(12'h203, 32'h22); wr(12'h204, 32'h33);
        slave_clear();
        run(2, 1, cyc, cs_seen, mv);
        chk("R6 busy cycles", cyc, 32'd54);
        chk("R9 cs during", {24'd0, cs_seen}, 32'hFB);
        chk("R3 edges", in_bits, 32'd24);
        chk("R3 mosi bytes", {8'd0, cap[0], cap[1], cap[2]}, 32'h00112233);
        rd(12'h200, d); chk("R3 buffer kept 0", d, 32'h40);
        rd(12'h201, d); chk("R3 buffer kept 1", d, 32'h03);
        rd(12'h202, d); chk("R3 buffer kept 2", d, 32'h11);
    endtask

    task automatic t_read_only();
        int cyc; logic [7:0] cs_seen; logic mv; logic [31:0] d;
        wr(12'h10C, 32'h5A);
        rd(12'h10C, d); chk("R4 fill readback", d, 32'h5A);
        put_hdr(16'h6004);
        slave_clear();
        run(0, 3, cyc, cs_seen, mv);
        chk("R6 busy cycles", cyc, 32'd72);
        chk("R4 fill on mosi", {cap[0], cap[1], cap[2], cap[3]}, 32'h5A5A5A5A);
        for (int k = 0; k < 4; k++) begin
            rd(12'(12'h200 + k), d);
            chk("R4 rx stored", d, {24'd0, pat(k)});
        end
    endtask

    task automatic t_read_write();
        int cyc; logic [7:0] cs_seen; logic mv; logic [31:0] d;
        put_hdr(16'h2803);   // opcode 1 with dual flag set
        wr(12'h202, 32'hA1); wr(12'h203, 32'hB2); wr(12'h204, 32'hC3);
        slave_clear();
        run(4, 0, cyc, cs_seen, mv);
        chk("R5 mosi bytes", {8'd0, cap[0], cap[1], cap[2]}, 32'h00A1B2C3);
        chk("R2 dual ignored edges", in_bits, 32'd24);
        for (int k = 0; k < 3; k++) begin
            rd(12'(12'h200 + k), d);
            chk("R5 rx stored", d, {24'd0, pat(k)});
        end
        rd(12'h204, d); chk("R5 tx byte kept", d, 32'hC3);
    endtask

    task automatic t_header_long();
        int cyc; logic [7:0] cs_seen; logic mv; int miss;
        put_hdr(16'h4102);   // write-only, count 258 across both header bytes
        for (int k = 0; k < 258; k++) wr(12'(12'h202 + k), 32'(8'(k * 3 + 1)));
        slave_clear();
        run(1, 0, cyc, cs_seen, mv);
        chk("R2 long count cycles", cyc, 32'd4644);
        chk("R2 long count edges", in_bits, 32'd2064);
        miss = 0;
        for (int k = 0; k < 258; k++) if (cap[k] !== 8'(k * 3 + 1)) miss++;
        chk("R2 long payload mismatches", miss, 32'd0);
    endtask

    task automatic t_busy_ignore();
        int cyc; logic [31:0] s; logic [7:0] cs_mid; logic [7:0] cs_after;
        put_hdr(16'h4002);
        wr(12'h202, 32'h6C); wr(12'h203, 32'h93);
        slave_clear();
        wr(12'h004, 32'h1 | (1 << 12));
        for (int i = 0; i < 5; i++) rd(12'h008, s);
        wr(12'h004, 32'h1 | (5 << 12));
        cs_mid = cs;
        cyc = 6;
        do begin
            rd(12'h008, s);
            if (s[1]) cyc++;
        end while (s[1] && cyc < 20000);
        cs_after = cs;
        chk("R7 cs kept", {24'd0, cs_mid}, 32'hFD);
        chk("R7 length kept", cyc, 32'd36);
        chk("R7 bytes", {16'd0, cap[0], cap[1]}, 32'h6C93);
        chk("R7 no second run", {24'd0, cs_after}, 32'hFF);
    endtask

    task automatic t_zero();
        logic [31:0] s; logic [7:0] c;
        put_hdr(16'h4000);
        slave_clear();
        wr(12'h004, 32'h1 | (3 << 12));
        c = cs;
        rd(12'h008, s);
        chk("R8 not busy", s, 32'h0);
        chk("R8 cs idle", {24'd0, c}, 32'hFF);
        for (int i = 0; i < 20; i++) @(negedge clk);
        chk("R8 no edges", in_bits, 32'd0);
    endtask

    task automatic t_polarity();
        int cyc; logic [7:0] cs_seen; logic mv;
        wr(12'h000, 32'h0001_000F);
        chk("R9 idle polarity", {24'd0, cs}, 32'h0F);
        put_hdr(16'h4001);
        wr(12'h202, 32'hE7);
        slave_clear();
        run(6, 0, cyc, cs_seen, mv);
        chk("R9 active high line", {24'd0, cs_seen}, 32'h4F);
        chk("R9 back to idle", {24'd0, cs}, 32'h0F);
        chk("R9 byte", {24'd0, cap[0]}, 32'hE7);
    endtask

    task automatic t_clock();
        int cyc; logic [7:0] cs_seen; logic mv;
        wr(12'h000, 32'h0003_00FF);
        cpol_tb = 1'b1;
        slave_clear();
        chk("R10 idle high", {31'd0, sclk}, 32'h1);
        put_hdr(16'h4001);
        wr(12'h202, 32'h96);
        run(0, 0, cyc, cs_seen, mv);
        chk("R10 cpol byte", {24'd0, cap[0]}, 32'h96);
        chk("R10 cpol edges", in_bits, 32'd8);
        wr(12'h000, 32'h0002_00FF);
        slave_clear();
        run(0, 0, cyc, cs_seen, mv);
        chk("R10 gate off edges", in_bits, 32'd0);
        chk("R10 gate off still", {31'd0, mv}, 32'h0);
        chk("R10 gate off level", {31'd0, sclk}, 32'h1);
    endtask

    initial begin
        #(4 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        slave_clear();
        t_reset();
        wr(12'h000, 32'h0001_00FF);
        slave_clear();
        t_write_only();
        t_read_only();
        t_read_write();
        t_header_long();
        t_busy_ignore();
        t_zero();
        t_polarity();
        t_clock();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule